// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This block carries out in-band software flow control for a single serial channel. Received bytes arrive one at a time on a strobe. The block compares them against programmable XOFF and XON characters, which are one byte or a two-byte pair. A detected XOFF pauses the local transmitter and a detected XON releases it. Flow-control characters that match are removed from the stream. Every other byte goes on to the receive FIFO in its arrival order.

The block also watches the fill count of the receive FIFO. When the count climbs to the selected trigger level, the block asks the transmitter to insert XOFF. When the count drops back to the next lower level, it asks the transmitter to insert XON. If flow control is switched off while a sent XOFF is still outstanding, the block sends XON by itself. A status flag shows that the transmitter is paused by a received XOFF, and an interrupt output follows that flag when interrupts are enabled.

Top module: `inband_flow_ctl`

## Requirements
- R1: The four character registers reset to 0x00 and are loaded through `reg_we`/`reg_addr`/`reg_wdata`, with address 0 = XOFF first byte, 1 = XOFF second byte, 2 = XON first byte, 3 = XON second byte.
- R2: In single-character mode (`cfg_two`=0) with flow control enabled, a received byte equal to the XOFF first byte pauses the transmitter while running. A byte equal to the XON first byte resumes it while paused. Matched bytes are not written to the FIFO. All other bytes are written once each, in order, on `fifo_wr`/`fifo_data`.
- R3: In two-character mode (`cfg_two`=1), XOFF is detected only when the XOFF first byte is followed directly by the XOFF second byte, and XON is detected the same way with the XON pair. Both bytes of a matched pair are kept out of the FIFO.
- R4: In two-character mode, if a held first byte is followed by a byte other than the second byte, the held byte is written to the FIFO first. The new byte is then written too, unless it is itself a first byte, in which case it is held as a new candidate.
- R5: `xoff_flag` is 1 from a detected XOFF until the transmitter is resumed. `irq` equals `xoff_flag` when `cfg_irq_en`=1 and stays 0 otherwise.
- R6: With `cfg_any`=1, any byte received while paused resumes the transmitter. That byte is written to the FIFO, except when it equals the XON first byte in single-character mode.
- R7: `tx_gate` (normal data may start) is 0 while paused or while an insertion is pending, and 1 otherwise. It changes only in cycles where `tx_busy` is 0, so a character already being sent is never cut short.
- R8: `cfg_sel` selects the trigger level as 0→8, 1→16, 2→56, 3→60 and the release level as 0→0, 1→8, 2→16, 3→56. When no XOFF is outstanding and `rx_level` ≥ trigger, XOFF is inserted once. When an XOFF is outstanding and `rx_level` ≤ release, XON is inserted once.
- R9: `ins_req` stays 1 with `ins_char` valid until `ins_ack`. In two-character mode the first byte is sent, then the second byte, and then the request drops.
- R10: Clearing `cfg_en` while a sent XOFF is outstanding inserts the XON character(s). It also clears the pause and `xoff_flag`, and writes any held first byte to the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Software flow control enable |
| cfg_two | input | 1 | Two-character sequence mode |
| cfg_any | input | 1 | Resume on any received character |
| cfg_irq_en | input | 1 | Received-XOFF interrupt enable |
| cfg_sel | input | 2 | Trigger level select |
| reg_we | input | 1 | Character register write strobe |
| reg_addr | input | 2 | Character register address |
| reg_wdata | input | DW | Character register write data |
| rx_vld | input | 1 | Received byte strobe |
| rx_data | input | DW | Received byte |
| fifo_wr | output | 1 | Write strobe toward receive FIFO |
| fifo_data | output | DW | Byte toward receive FIFO |
| rx_level | input | CW | Receive FIFO fill count |
| tx_busy | input | 1 | Transmitter is sending a character |
| tx_gate | output | 1 | Normal transmit data may start |
| ins_req | output | 1 | Flow character insertion request |
| ins_char | output | DW | Character to insert |
| ins_ack | input | 1 | Transmitter took the inserted character |
| xoff_flag | output | 1 | Paused by received XOFF |
| irq | output | 1 | Received-XOFF interrupt |

## Verification
The assertions assume that received strobes are at least two clock cycles apart. This leaves room for the extra FIFO write that a broken pair causes. They also assume that `ins_ack` is raised only while `ins_req` is high, and that the mode bits do not change while a first byte is being held. The bench sends each byte as a one-cycle strobe followed by an idle cycle. It raises `ins_ack` only after it has seen a request, and it changes mode bits only between byte sequences. Random data bytes are drawn so that they never match a programmed flow character.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
   // character register addresses
   typedef enum logic [1:0] {
      SEL_XOFF1 = 2'd0,
      SEL_XOFF2 = 2'd1,
      SEL_XON1  = 2'd2,
      SEL_XON2  = 2'd3
   } chr_sel_e;

   typedef enum logic {
      K_XON  = 1'b0,
      K_XOFF = 1'b1
   } flow_kind_e;
endpackage

// File: rtl/ifc_chr_regs.sv
module ifc_chr_regs #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [1:0]    addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] xoff1,
   output logic [DW-1:0] xoff2,
   output logic [DW-1:0] xon1,
   output logic [DW-1:0] xon2
);
   localparam int NREG = 4;
   logic [NREG*DW-1:0] chr_flat;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (we && addr == 2'(g))
            q <= wdata;
      end
      assign chr_flat[g*DW +: DW] = q;
   end

   assign xoff1 = chr_flat[int'(ifc_pkg::SEL_XOFF1)*DW +: DW];
   assign xoff2 = chr_flat[int'(ifc_pkg::SEL_XOFF2)*DW +: DW];
   assign xon1  = chr_flat[int'(ifc_pkg::SEL_XON1)*DW +: DW];
   assign xon2  = chr_flat[int'(ifc_pkg::SEL_XON2)*DW +: DW];
endmodule

// File: rtl/ifc_rx_match.sv
module ifc_rx_match #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          two,
   input  logic          any,
   input  logic          rx_vld,
   input  logic [DW-1:0] rx_data,
   input  logic [DW-1:0] xoff1,
   input  logic [DW-1:0] xoff2,
   input  logic [DW-1:0] xon1,
   input  logic [DW-1:0] xon2,
   output logic          fifo_wr,
   output logic [DW-1:0] fifo_data,
   output logic          halted
);
   logic          held_q, pend_q, halt_q, wr_q;
   logic [DW-1:0] hb_q, pb_q, dat_q;
   logic [DW-1:0] t1, t2;

   // while running look for XOFF, while paused look for XON
   always_comb begin
      t1 = halt_q ? xon1 : xoff1;
      t2 = halt_q ? xon2 : xoff2;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         pend_q <= 1'b0;
         halt_q <= 1'b0;
         wr_q   <= 1'b0;
         hb_q   <= '0;
         pb_q   <= '0;
         dat_q  <= '0;
      end else begin
         wr_q <= 1'b0;
         if (pend_q) begin
            wr_q   <= 1'b1;
            dat_q  <= pb_q;
            pend_q <= 1'b0;
         end else if (!en) begin
            halt_q <= 1'b0;
            if (held_q) begin
               wr_q   <= 1'b1;
               dat_q  <= hb_q;
               held_q <= 1'b0;
            end else if (rx_vld) begin
               wr_q  <= 1'b1;
               dat_q <= rx_data;
            end
         end else if (rx_vld) begin
            if (halt_q && any) begin
               halt_q <= 1'b0;
               held_q <= 1'b0;
               if (two || rx_data != xon1) begin
                  wr_q  <= 1'b1;
                  dat_q <= rx_data;
               end
            end else if (!two) begin
               if (rx_data == t1) begin
                  halt_q <= !halt_q;
               end else begin
                  wr_q  <= 1'b1;
                  dat_q <= rx_data;
               end
            end else if (!held_q) begin
               if (rx_data == t1) begin
                  held_q <= 1'b1;
                  hb_q   <= rx_data;
               end else begin
                  wr_q  <= 1'b1;
                  dat_q <= rx_data;
               end
            end else if (rx_data == t2) begin
               held_q <= 1'b0;
               halt_q <= !halt_q;
            end else begin
               // broken pair: release held byte, re-examine the new one
               wr_q  <= 1'b1;
               dat_q <= hb_q;
               if (rx_data == t1) begin
                  hb_q <= rx_data;
               end else begin
                  held_q <= 1'b0;
                  pend_q <= 1'b1;
                  pb_q   <= rx_data;
               end
            end
         end
      end
   end

   assign fifo_wr   = wr_q;
   assign fifo_data = dat_q;
   assign halted    = halt_q;
endmodule

// File: rtl/ifc_tx_pace.sv
module ifc_tx_pace #(
   parameter int DW = 8,
   parameter int CW = 7,
   parameter int L0 = 8,
   parameter int L1 = 16,
   parameter int L2 = 56,
   parameter int L3 = 60
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          two,
   input  logic [1:0]    sel,
   input  logic [CW-1:0] level,
   input  logic [DW-1:0] xoff1,
   input  logic [DW-1:0] xoff2,
   input  logic [DW-1:0] xon1,
   input  logic [DW-1:0] xon2,
   input  logic          ins_ack,
   output logic          ins_req,
   output logic [DW-1:0] ins_char
);
   import ifc_pkg::*;

   localparam logic [CW-1:0] H0 = CW'(L0);
   localparam logic [CW-1:0] H1 = CW'(L1);
   localparam logic [CW-1:0] H2 = CW'(L2);
   localparam logic [CW-1:0] H3 = CW'(L3);

   if (!(L0 > 0 && L0 < L1 && L1 < L2 && L2 < L3 && L3 < (1 << CW))) begin : g_bad_levels
      $error("ifc_tx_pace: trigger levels must ascend and fit the fill count width");
   end

   function automatic logic [CW-1:0] hi_of(input logic [1:0] s);
      case (s)
         2'd0:    return H0;
         2'd1:    return H1;
         2'd2:    return H2;
         default: return H3;
      endcase
   endfunction

   function automatic logic [CW-1:0] lo_of(input logic [1:0] s);
      case (s)
         2'd0:    return '0;
         2'd1:    return H0;
         2'd2:    return H1;
         default: return H2;
      endcase
   endfunction

   logic       act_q, idx_q, off_q;
   flow_kind_e kind_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         idx_q  <= 1'b0;
         off_q  <= 1'b0;
         kind_q <= K_XON;
      end else if (act_q) begin
         if (ins_ack) begin
            if (two && !idx_q) begin
               idx_q <= 1'b1;
            end else begin
               act_q <= 1'b0;
               idx_q <= 1'b0;
            end
         end
      end else if (en && !off_q && level >= hi_of(sel)) begin
         act_q  <= 1'b1;
         kind_q <= K_XOFF;
         off_q  <= 1'b1;
      end else if (off_q && (!en || level <= lo_of(sel))) begin
         act_q  <= 1'b1;
         kind_q <= K_XON;
         off_q  <= 1'b0;
      end
   end

   always_comb begin
      case ({kind_q == K_XOFF, idx_q})
         2'b10:   ins_char = xoff1;
         2'b11:   ins_char = xoff2;
         2'b01:   ins_char = xon2;
         default: ins_char = xon1;
      endcase
   end

   assign ins_req = act_q;
endmodule

// File: rtl/inband_flow_ctl.sv
module inband_flow_ctl #(
   parameter int DW = 8,
   parameter int CW = 7,
   parameter int L0 = 8,
   parameter int L1 = 16,
   parameter int L2 = 56,
   parameter int L3 = 60
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_en,
   input  logic          cfg_two,
   input  logic          cfg_any,
   input  logic          cfg_irq_en,
   input  logic [1:0]    cfg_sel,
   input  logic          reg_we,
   input  logic [1:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   input  logic          rx_vld,
   input  logic [DW-1:0] rx_data,
   output logic          fifo_wr,
   output logic [DW-1:0] fifo_data,
   input  logic [CW-1:0] rx_level,
   input  logic          tx_busy,
   output logic          tx_gate,
   output logic          ins_req,
   output logic [DW-1:0] ins_char,
   input  logic          ins_ack,
   output logic          xoff_flag,
   output logic          irq
);
   if (DW < 1) begin : g_bad_dw
      $error("inband_flow_ctl: DW must be positive");
   end

   logic [DW-1:0] xoff1, xoff2, xon1, xon2;
   logic          halted;
   logic          gate_q;

   ifc_chr_regs #(.DW(DW)) i_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .xoff1 (xoff1),
      .xoff2 (xoff2),
      .xon1  (xon1),
      .xon2  (xon2)
   );

   ifc_rx_match #(.DW(DW)) i_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (cfg_en),
      .two       (cfg_two),
      .any       (cfg_any),
      .rx_vld    (rx_vld),
      .rx_data   (rx_data),
      .xoff1     (xoff1),
      .xoff2     (xoff2),
      .xon1      (xon1),
      .xon2      (xon2),
      .fifo_wr   (fifo_wr),
      .fifo_data (fifo_data),
      .halted    (halted)
   );

   ifc_tx_pace #(.DW(DW), .CW(CW), .L0(L0), .L1(L1), .L2(L2), .L3(L3)) i_pace (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg_en),
      .two      (cfg_two),
      .sel      (cfg_sel),
      .level    (rx_level),
      .xoff1    (xoff1),
      .xoff2    (xoff2),
      .xon1     (xon1),
      .xon2     (xon2),
      .ins_ack  (ins_ack),
      .ins_req  (ins_req),
      .ins_char (ins_char)
   );

   // gate is re-evaluated only between characters
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gate_q <= 1'b1;
      else if (!tx_busy)
         gate_q <= !halted && !ins_req;
   end

   assign tx_gate   = gate_q;
   assign xoff_flag = halted;
   assign irq       = halted & cfg_irq_en;
endmodule

// File: rtl/ifc_chk.sv
module ifc_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_en,
   input logic cfg_irq_en,
   input logic rx_vld,
   input logic tx_busy,
   input logic tx_gate,
   input logic ins_req,
   input logic ins_ack,
   input logic xoff_flag,
   input logic irq
);
   // R7
   gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |=> $stable(tx_gate));

   // R5
   flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xoff_flag) |-> $past(rx_vld));

   // R5
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_irq_en || !xoff_flag) |-> !irq);

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_req && !ins_ack) |=> ins_req);

   // R10
   off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> !xoff_flag);
endmodule

bind inband_flow_ctl ifc_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_en     (cfg_en),
   .cfg_irq_en (cfg_irq_en),
   .rx_vld     (rx_vld),
   .tx_busy    (tx_busy),
   .tx_gate    (tx_gate),
   .ins_req    (ins_req),
   .ins_ack    (ins_ack),
   .xoff_flag  (xoff_flag),
   .irq        (irq)
);

// File: tb/test_inband_flow_ctl.sv
module test_inband_flow_ctl;
   localparam int DW = 8;
   localparam int CW = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_en = 1'b0, cfg_two = 1'b0, cfg_any = 1'b0, cfg_irq_en = 1'b0;
   logic [1:0] cfg_sel = 2'd0;
   logic reg_we = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [DW-1:0] reg_wdata = '0;
   logic rx_vld = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic fifo_wr;
   logic [DW-1:0] fifo_data;
   logic [CW-1:0] rx_level = '0;
   logic tx_busy = 1'b0;
   logic tx_gate, ins_req, xoff_flag, irq;
   logic [DW-1:0] ins_char;
   logic ins_ack = 1'b0;

   int n_chk = 0;
   int n_err = 0;
   logic [DW-1:0] cap[$];
   logic [DW-1:0] exq[$];

   localparam logic [7:0] XF1 = 8'h13, XF2 = 8'h93, XN1 = 8'h11, XN2 = 8'h91;

   always #2.5 clk = ~clk;

   inband_flow_ctl #(.DW(DW), .CW(CW)) i_inband_flow_ctl (.*);

   always @(negedge clk)
      if (rst_n && fifo_wr) cap.push_back(fifo_data);

   task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
      n_chk++;
      if (a !== e) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic send(input logic [7:0] b);
      rx_vld = 1'b1; rx_data = b;
      tick;
      rx_vld = 1'b0;
      tick;
   endtask

   task automatic wreg(input logic [1:0] a, input logic [7:0] v);
      reg_we = 1'b1; reg_addr = a; reg_wdata = v;
      tick;
      reg_we = 1'b0;
   endtask

   task automatic ack;
      ins_ack = 1'b1;
      tick;
      ins_ack = 1'b0;
   endtask

   task automatic cmp_stream(input string tag);
      chk({tag, " count"}, cap.size(), exq.size());
      for (int i = 0; i < exq.size() && i < cap.size(); i++)
         chk({tag, " byte"}, cap[i], exq[i]);
      cap.delete();
      exq.delete();
   endtask

   function automatic int hi_lvl(input int s);
      return (s == 0) ? 8 : (s == 1) ? 16 : (s == 2) ? 56 : 60;
   endfunction

   function automatic int lo_lvl(input int s);
      return (s == 0) ? 0 : (s == 1) ? 8 : (s == 2) ? 16 : 56;
   endfunction

   function automatic logic is_flow(input logic [7:0] b);
      return (b == XF1 || b == XF2 || b == XN1 || b == XN2);
   endfunction

   initial begin
      #500us;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic off;
      void'($urandom(32'h1f5e_ed07));
      @(negedge clk);
      tick;
      rst_n = 1'b1;
      // reset state
      chk("reset fifo_wr", fifo_wr, 0);
      chk("R9 reset ins_req", ins_req, 0);
      chk("R7 reset tx_gate", tx_gate, 1);
      chk("R5 reset flag", xoff_flag, 0);
      chk("R5 reset irq", irq, 0);

      // R1: registers reset to zero, so 0x00 acts as XOFF then XON
      cfg_en = 1'b1; cfg_irq_en = 1'b1;
      send(8'h00);
      chk("R1 zero XOFF flag", xoff_flag, 1);
      chk("R5 irq enabled", irq, 1);
      send(8'h00);
      chk("R1 zero XON flag", xoff_flag, 0);
      cmp_stream("R1 zero chars dropped");

      wreg(2'd0, XF1); wreg(2'd1, XF2); wreg(2'd2, XN1); wreg(2'd3, XN2);

      // R2: random data passes in order
      for (int i = 0; i < 24; i++) begin
         logic [7:0] b;
         b = 8'($urandom);
         while (is_flow(b)) b = 8'($urandom);
         send(b);
         exq.push_back(b);
      end
      cmp_stream("R2 random pass");
      send(XF1);
      chk("R2 XOFF single", xoff_flag, 1);
      chk("R7 gate paused", tx_gate, 0);
      send(8'h41); exq.push_back(8'h41);
      send(XN1);
      chk("R2 XON single", xoff_flag, 0);
      chk("R7 gate resumed", tx_gate, 1);
      cmp_stream("R2 flow dropped");

      // R5: mask
      cfg_irq_en = 1'b0;
      send(XF1);
      chk("R5 flag masked", xoff_flag, 1);
      chk("R5 irq masked", irq, 0);
      send(XN1);
      cfg_irq_en = 1'b1;

      // R3 / R4: two-character mode
      cfg_two = 1'b1;
      send(XF1); send(XF2);
      chk("R3 pair XOFF", xoff_flag, 1);
      cmp_stream("R3 pair dropped");
      send(XF1); send(XF2); exq.push_back(XF1); exq.push_back(XF2);
      send(XN1); send(8'h55); exq.push_back(XN1); exq.push_back(8'h55);
      chk("R4 broken XON keeps pause", xoff_flag, 1);
      send(XN1); send(XN2);
      chk("R3 pair XON", xoff_flag, 0);
      cmp_stream("R4 while paused");
      send(XF1); send(8'h42); exq.push_back(XF1); exq.push_back(8'h42);
      chk("R4 broken XOFF", xoff_flag, 0);
      send(XF1); send(XF1); send(XF2); exq.push_back(XF1);
      chk("R4 re-held first byte", xoff_flag, 1);
      send(XN1); send(XN2);
      cmp_stream("R4 streams");

      // R6: any-character resume
      cfg_two = 1'b0; cfg_any = 1'b1;
      send(XF1);
      send(8'h40); exq.push_back(8'h40);
      chk("R6 any resumes", xoff_flag, 0);
      send(XF1);
      send(XN1);
      chk("R6 XON resumes", xoff_flag, 0);
      cmp_stream("R6 stream");
      cfg_any = 1'b0;

      // R7: pause takes effect after character in progress
      tx_busy = 1'b1;
      send(XF1);
      chk("R7 busy holds gate", tx_gate, 1);
      tx_busy = 1'b0;
      tick;
      chk("R7 gate drops after char", tx_gate, 0);
      send(XN1);
      chk("R7 gate back", tx_gate, 1);

      // R8 / R9: trigger hysteresis, single character
      cfg_sel = 2'd1;
      rx_level = 7'd15; tick;
      chk("R8 below trigger", ins_req, 0);
      rx_level = 7'd16; tick;
      chk("R8 XOFF request", ins_req, 1);
      chk("R8 XOFF char", ins_char, XF1);
      tick;
      chk("R7 gate low on insert", tx_gate, 0);
      chk("R9 request held", ins_req, 1);
      ack;
      chk("R9 request done", ins_req, 0);
      tick;
      chk("R8 no repeat", ins_req, 0);
      rx_level = 7'd9; tick;
      chk("R8 above release", ins_req, 0);
      rx_level = 7'd8; tick;
      chk("R8 XON request", ins_req, 1);
      chk("R8 XON char", ins_char, XN1);
      ack;

      // R8 random levels against a bench model
      off = 1'b0;
      for (int i = 0; i < 40; i++) begin
         int lv;
         lv = int'($urandom % 64);
         rx_level = 7'(lv);
         tick;
         if (!off && lv >= hi_lvl(1)) begin
            chk("R8 rand req", ins_req, 1); chk("R8 rand char", ins_char, XF1);
            off = 1'b1; ack;
         end else if (off && lv <= lo_lvl(1)) begin
            chk("R8 rand req", ins_req, 1); chk("R8 rand char", ins_char, XN1);
            off = 1'b0; ack;
         end else begin
            chk("R8 rand idle", ins_req, 0);
         end
      end
      if (off) begin
         rx_level = '0; tick;
         chk("R8 rand final XON", ins_char, XN1);
         ack;
      end

      // R9: two-character insertion at level 60
      cfg_two = 1'b1; cfg_sel = 2'd3;
      rx_level = 7'd59; tick;
      chk("R8 59 below 60", ins_req, 0);
      rx_level = 7'd60; tick;
      chk("R9 pair first", ins_char, XF1);
      ack;
      chk("R9 pair second req", ins_req, 1);
      chk("R9 pair second", ins_char, XF2);
      ack;
      chk("R9 pair done", ins_req, 0);

      // R10: disable sends XON pair and clears pause
      send(XF1); send(XF2);
      chk("R10 paused before disable", xoff_flag, 1);
      cfg_en = 1'b0; tick;
      chk("R10 flag cleared", xoff_flag, 0);
      chk("R10 auto XON", ins_char, XN1);
      chk("R10 auto XON req", ins_req, 1);
      ack;
      chk("R10 auto XON second", ins_char, XN2);
      ack;
      chk("R10 auto XON done", ins_req, 0);
      rx_level = '0;
      cfg_en = 1'b1;
      send(XF1);
      cfg_en = 1'b0; tick; tick;
      exq.push_back(XF1);
      cmp_stream("R10 held byte flushed");

      // R8: lowest level releases at zero
      cfg_en = 1'b1; cfg_two = 1'b0; cfg_sel = 2'd0;
      rx_level = 7'd8; tick;
      chk("R8 level 8 XOFF", ins_char, XF1);
      ack;
      rx_level = 7'd1; tick;
      chk("R8 level 1 holds", ins_req, 0);
      rx_level = 7'd0; tick;
      chk("R8 level 0 XON", ins_req, 1);
      chk("R8 level 0 char", ins_char, XN1);
      ack;

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule